// File: doc/BRIEF.md
# Tuner configuration register I2C slave

This block is the serial control port of a satellite tuner. It sits on a two-wire I2C-compatible bus as a slave. It holds twelve byte-wide configuration registers that drive the tuner's analog and synthesizer settings as parallel fields. It also answers reads with two status bytes built from live inputs: the VCO search result, the PLL lock and the VCO band and tuning ADC code. Both bus lines are sampled on the system clock. Each line passes through a synchronizer and a glitch filter before START, STOP and clock edges are decoded. SDA is driven open-drain through a single pull-low output.

A bus master writes by sending the slave address with the write bit, a register pointer, and then any number of data bytes. Each data byte lands at the pointer, and the pointer advances by one after each byte. A read ignores the pointer. It always streams status byte 1 first and then status byte 2. A power-on flag in status byte 1 reads 1 after reset and stays 1 until a status read has been closed with STOP. Writing the N-divider low byte raises a one-cycle strobe, which starts the downstream VCO search.

Top module: `tuner_i2c_regs`

## Requirements
- R1: After reset the registers hold 0x03 (index 0), 0xB6 (1), 0x04 (5), 0xC0 (6), 0xCC (7) and 0x4B (8), and 0x00 at every other index. SDA is released and the strobe is low.
- R2: The slave answers only address 0b110000x. The low bit x is 0 when addr_sel_i is 1 and 1 when addr_sel_i is 0. Another address is not acknowledged, and the rest of that transaction is ignored until the next START.
- R3: A write is address with R/W=0, then a pointer byte, then data bytes. Bits arrive most significant first and are sampled on the rising edge of SCL. Every byte is acknowledged by pulling SDA low in the ninth clock. Each data byte is stored at the pointer, which then advances by one.
- R4: Pointer values of 12 and above are acknowledged, but their data bytes are discarded and no register changes. A burst that runs past index 11 discards its remaining bytes.
- R5: An acknowledged data byte stored at index 1 produces exactly one clock-wide pulse on n_low_strobe_o, in the cycle the new value appears. A write to any other index produces no pulse.
- R6: A read (R/W=1) returns status byte 1 and then status byte 2, whatever the pointer holds. Status byte 1 is {power-on flag, search_ok, search_idle, pll_lock, 0000} from bit 7 down. Status byte 2 is {vco_band[4:0], tune_adc[2:0]}. While the master acknowledges, the bytes keep alternating.
- R7: The power-on flag is 1 after reset. It clears when a read transaction ends with STOP. A read that ends with a repeated START leaves it set.
- R8: A pulse shorter than FILT_LEN system clocks on SCL or SDA has no effect. No bit is added, and no START or STOP is seen.
- R9: SDA is only ever pulled low. The pull output changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 1 | Address select, 1 picks 0x60, 0 picks 0x61 |
| search_ok_i | input | 1 | VCO search succeeded (status byte 1 bit 6) |
| search_idle_i | input | 1 | VCO search not running (status byte 1 bit 5) |
| pll_lock_i | input | 1 | PLL lock indication (status byte 1 bit 4) |
| vco_band_i | input | 5 | Selected VCO band (status byte 2 bits 7:3) |
| tune_adc_i | input | 3 | Tuning voltage ADC code (status byte 2 bits 2:0) |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_regs_o | output | NUM_REGS*8 | Register k in bits 8k+7:8k |
| n_low_strobe_o | output | 1 | One-cycle pulse on a write to index 1 |

## Verification
The bench builds the block with its defaults: twelve registers, a two-stage synchronizer, a four-clock glitch filter and base address 0x60. It runs the bus with twenty system clocks per quarter bit. Two-clock spikes on SCL during a low phase and on SDA during a high phase therefore fall below the filter length, and genuine edges still clear it easily. That makes glitch rejection visible in the stored register value. With only twelve registers, a three-byte burst from index 11 runs the pointer off the end. A pointer of 0x40 checks the out-of-range discard. Both address-select settings are exercised against both candidate addresses.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } eng_phase_t;

  localparam int PTR_W = 8;

  // Power-up value of each configuration register.
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h03;
      1:       return 8'hB6;
      5:       return 8'h04;
      6:       return 8'hC0;
      7:       return 8'hCC;
      8:       return 8'h4B;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/tuner_i2c_deglitch.sv
module tuner_i2c_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q, cnt_n;
  logic                   filt_q, filt_n;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  // The filtered level follows the synced level only after it has differed
  // for FILT_LEN consecutive clocks.
  always_comb begin
    cnt_n  = '0;
    filt_n = filt_q;
    if (synced != filt_q) begin
      if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        filt_n = synced;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      cnt_q  <= cnt_n;
      filt_q <= filt_n;
    end
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/tuner_i2c_engine.sv
module tuner_i2c_engine
  import tuner_i2c_pkg::*;
#(
  parameter int         NUM_REGS  = 12,
  parameter logic [6:0] BASE_ADDR = 7'h60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_f,
  input  logic             sda_f,
  input  logic             addr_sel,
  input  logic [7:0]       stat1,
  input  logic [7:0]       stat2,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             read_stop,
  output logic             start_det,
  output logic             stop_det,
  output logic             sda_pull
);
  eng_state_t       state, state_n;
  eng_phase_t       phase, phase_n;
  logic [2:0]       bitcnt, bitcnt_n;
  logic [7:0]       sh, sh_n;
  logic             got, got_n;
  logic             rw, rw_n;
  logic [PTR_W-1:0] ptr, ptr_n;
  logic             drive, drive_n;
  logic             mack, mack_n;
  logic             nxt_sel, nxt_sel_n;
  logic             rd_seen, rd_seen_n;
  logic             scl_q, sda_q;
  logic             scl_rise, scl_fall;
  logic [6:0]       my_addr;
  logic [7:0]       nxt_byte;

  assign my_addr   = {BASE_ADDR[6:1], BASE_ADDR[0] ^ ~addr_sel};
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign nxt_byte  = nxt_sel ? stat2 : stat1;
  assign wr_addr   = ptr;
  assign wr_data   = sh;
  assign sda_pull  = drive;

  always_comb begin
    state_n   = state;
    phase_n   = phase;
    bitcnt_n  = bitcnt;
    sh_n      = sh;
    got_n     = got;
    rw_n      = rw;
    ptr_n     = ptr;
    drive_n   = drive;
    mack_n    = mack;
    nxt_sel_n = nxt_sel;
    rd_seen_n = rd_seen;
    wr_en     = 1'b0;
    read_stop = 1'b0;
    if (start_det) begin
      state_n   = ST_RX;
      phase_n   = PH_ADDR;
      bitcnt_n  = 3'd0;
      got_n     = 1'b0;
      drive_n   = 1'b0;
      rd_seen_n = 1'b0;
    end else if (stop_det) begin
      state_n   = ST_IDLE;
      drive_n   = 1'b0;
      got_n     = 1'b0;
      read_stop = rd_seen;
      rd_seen_n = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
        end
        ST_RX: begin
          if (scl_rise) begin
            sh_n     = {sh[6:0], sda_f};
            bitcnt_n = bitcnt + 3'd1;
            if (bitcnt == 3'd7) got_n = 1'b1;
          end else if (scl_fall && got) begin
            got_n = 1'b0;
            unique case (phase)
              PH_ADDR: begin
                if (sh[7:1] == my_addr) begin
                  rw_n    = sh[0];
                  drive_n = 1'b1;
                  state_n = ST_ACK;
                  if (sh[0]) rd_seen_n = 1'b1;
                end else begin
                  state_n = ST_IDLE;
                end
              end
              PH_PTR: begin
                ptr_n   = sh;
                drive_n = 1'b1;
                state_n = ST_ACK;
              end
              default: begin
                wr_en   = 1'b1;
                drive_n = 1'b1;
                state_n = ST_ACK;
                if (ptr < PTR_W'(NUM_REGS)) ptr_n = ptr + PTR_W'(1);
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt_n = 3'd0;
            if (phase == PH_ADDR && rw) begin
              state_n   = ST_TX;
              sh_n      = stat1;
              nxt_sel_n = 1'b1;
              drive_n   = ~stat1[7];
            end else begin
              drive_n = 1'b0;
              state_n = ST_RX;
              phase_n = (phase == PH_ADDR) ? PH_PTR : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              state_n = ST_MACK;
              drive_n = 1'b0;
            end else begin
              sh_n     = {sh[6:0], 1'b0};
              bitcnt_n = bitcnt + 3'd1;
              drive_n  = ~sh[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_n = ~sda_f;
          end else if (scl_fall) begin
            if (mack) begin
              state_n   = ST_TX;
              sh_n      = nxt_byte;
              nxt_sel_n = ~nxt_sel;
              bitcnt_n  = 3'd0;
              drive_n   = ~nxt_byte[7];
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      phase   <= PH_ADDR;
      bitcnt  <= 3'd0;
      sh      <= 8'h00;
      got     <= 1'b0;
      rw      <= 1'b0;
      ptr     <= '0;
      drive   <= 1'b0;
      mack    <= 1'b0;
      nxt_sel <= 1'b0;
      rd_seen <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      state   <= state_n;
      phase   <= phase_n;
      bitcnt  <= bitcnt_n;
      sh      <= sh_n;
      got     <= got_n;
      rw      <= rw_n;
      ptr     <= ptr_n;
      drive   <= drive_n;
      mack    <= mack_n;
      nxt_sel <= nxt_sel_n;
      rd_seen <= rd_seen_n;
      scl_q   <= scl_f;
      sda_q   <= sda_f;
    end
  end

endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
  import tuner_i2c_pkg::*;
#(
  parameter int NUM_REGS   = 12,
  parameter int STROBE_IDX = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  read_stop,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  strobe_o,
  output logic                  por_o
);
  logic strobe_n;
  logic por_q, por_n;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] val_q;
    logic       hit;
    assign hit = wr_en && (wr_addr == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= reg_default(i);
      else if (hit) val_q <= wr_data;
    end
    assign regs_o[i*8 +: 8] = val_q;
  end

  assign strobe_n = wr_en && (wr_addr == PTR_W'(STROBE_IDX));
  assign por_n    = por_q & ~read_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_o <= 1'b0;
      por_q    <= 1'b1;
    end else begin
      strobe_o <= strobe_n;
      por_q    <= por_n;
    end
  end

  assign por_o = por_q;

endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
  import tuner_i2c_pkg::*;
#(
  parameter int         NUM_REGS    = 12,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 4,
  parameter logic [6:0] BASE_ADDR   = 7'h60
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_sel_i,
  input  logic                  search_ok_i,
  input  logic                  search_idle_i,
  input  logic                  pll_lock_i,
  input  logic [4:0]            vco_band_i,
  input  logic [2:0]            tune_adc_i,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] cfg_regs_o,
  output logic                  n_low_strobe_o
);
  localparam int N_LINES = 2;

  logic [1:0]         rst_ff;
  logic               rst_sync_n;
  logic [N_LINES-1:0] raw_lines, filt_lines;
  logic               scl_f, sda_f;
  logic               wr_en, read_stop, start_det, stop_det, por;
  logic [PTR_W-1:0]   wr_addr;
  logic [7:0]         wr_data;
  logic [7:0]         stat1, stat2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    tuner_i2c_deglitch #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_flt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .raw_i (raw_lines[g]),
      .filt_o(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  assign stat1 = {por, search_ok_i, search_idle_i, pll_lock_i, 4'b0000};
  assign stat2 = {vco_band_i, tune_adc_i};

  tuner_i2c_engine #(
    .NUM_REGS (NUM_REGS),
    .BASE_ADDR(BASE_ADDR)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .addr_sel (addr_sel_i),
    .stat1    (stat1),
    .stat2    (stat2),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .read_stop(read_stop),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_pull (sda_pull_o)
  );

  tuner_reg_bank #(
    .NUM_REGS  (NUM_REGS),
    .STROBE_IDX(1)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .read_stop(read_stop),
    .regs_o   (cfg_regs_o),
    .strobe_o (n_low_strobe_o),
    .por_o    (por)
  );

endmodule

// File: rtl/tuner_i2c_regs_chk.sv
module tuner_i2c_regs_chk
  import tuner_i2c_pkg::*;
#(
  parameter int NUM_REGS = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_f,
  input logic                  stop_det,
  input logic                  por,
  input logic                  wr_en,
  input logic [PTR_W-1:0]      wr_addr,
  input logic [7:0]            wr_data,
  input logic                  sda_pull_o,
  input logic                  n_low_strobe_o,
  input logic [NUM_REGS*8-1:0] cfg_regs_o
);

  p_pull_quiet_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_pull_o));

  p_por_clears_on_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por) |-> $past(stop_det));

  p_oor_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= PTR_W'(NUM_REGS)) |=> $stable(cfg_regs_o));

  p_strobe_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    n_low_strobe_o |-> (cfg_regs_o[15:8] == $past(wr_data)));

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    n_low_strobe_o |=> !n_low_strobe_o);

endmodule

bind tuner_i2c_regs tuner_i2c_regs_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .scl_f         (scl_f),
  .stop_det      (stop_det),
  .por           (por),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .sda_pull_o    (sda_pull_o),
  .n_low_strobe_o(n_low_strobe_o),
  .cfg_regs_o    (cfg_regs_o)
);

// File: tb/tb_tuner_i2c_regs.sv
`timescale 1ns/1ps
module tb_tuner_i2c_regs;
  localparam int NREG = 12;
  localparam int Q    = 20;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n, m_scl, m_sda, sda_bus, addr_sel;
  logic            s_ok, s_idle, lock;
  logic [4:0]      band;
  logic [2:0]      adc;
  logic            sda_pull, strobe;
  logic [NREG*8-1:0] regs;

  assign sda_bus = m_sda & ~sda_pull;

  tuner_i2c_regs dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .search_ok_i(s_ok), .search_idle_i(s_idle),
    .pll_lock_i(lock), .vco_band_i(band), .tune_adc_i(adc),
    .sda_pull_o(sda_pull), .cfg_regs_o(regs), .n_low_strobe_o(strobe)
  );

  int         n_tests = 0, n_fail = 0, strobe_cnt = 0;
  logic [7:0] model [NREG];
  logic       por_m;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] obs;
  event       obs_ev;

  always @(posedge clk) if (strobe === 1'b1) strobe_cnt++;

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    int bad = 0;
    n_tests++;
    for (int i = 0; i < NREG; i++)
      if (regs[i*8 +: 8] !== model[i]) begin
        bad++;
        $display("FAIL %s reg %0d: actual %0h expected %0h", req, i, regs[i*8 +: 8], model[i]);
      end
    if (bad != 0) n_fail++;
  endtask

  task automatic load_defaults();
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    model[0] = 8'h03; model[1] = 8'hB6; model[5] = 8'h04;
    model[6] = 8'hC0; model[7] = 8'hCC; model[8] = 8'h4B;
    por_m = 1'b1;
  endtask

  // Scoreboard monitor: compares each byte read from the bus with the queue.
  always @(obs_ev) begin
    n_tests++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R6 unexpected byte: actual %0h expected none", obs);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (obs !== e) begin
        n_fail++;
        $display("FAIL %s status byte: actual %0h expected %0h", t, obs, e);
      end
    end
  end

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_restart();
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b1; w(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); b = sda_bus; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic byte_out(input logic [7:0] v, input int glitch, output logic ack_n);
    for (int i = 7; i >= 0; i--) begin
      m_sda = v[i];
      if (glitch == 1 && i == 4) begin
        w(Q/2); m_scl = 1'b1; w(2); m_scl = 1'b0; w(Q/2 - 2);
      end else w(Q);
      m_scl = 1'b1;
      if (glitch == 2 && v[i]) begin
        w(Q - 2); m_sda = 1'b0; w(2); m_sda = 1'b1; w(Q);
      end else w(2*Q);
      m_scl = 1'b0; w(Q);
    end
    bit_in(ack_n);
  endtask

  task automatic byte_in(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; w(Q); m_scl = 1'b1; w(2*Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic write_regs(input logic [6:0] a, input logic [7:0] ptr, input logic [7:0] d [4],
                            input int n, input int glitch, input bit exp_ack, input string req);
    logic ack_n;
    int   idx;
    bus_start();
    byte_out({a, 1'b0}, 0, ack_n);
    check(exp_ack ? req : "R2", ack_n, exp_ack ? 0 : 1, "address ack");
    byte_out(ptr, 0, ack_n);
    check(req, ack_n, exp_ack ? 0 : 1, "pointer ack");
    for (int k = 0; k < n; k++) begin
      byte_out(d[k], glitch, ack_n);
      check(req, ack_n, exp_ack ? 0 : 1, "data ack");
      idx = int'(ptr) + k;
      if (exp_ack && idx < NREG) model[idx] = d[k];
    end
    bus_stop();
    w(12);
  endtask

  function automatic logic [7:0] s1();
    return {por_m, s_ok, s_idle, lock, 4'h0};
  endfunction

  task automatic read_status(input int nbytes, input bit end_restart, input string req);
    logic ack_n;
    logic [7:0] v;
    bus_start();
    byte_out({7'h60, 1'b1}, 0, ack_n);
    check(req, ack_n, 0, "read address ack");
    for (int k = 0; k < nbytes; k++) begin
      exp_q.push_back(k % 2 == 0 ? s1() : {band, adc});
      tag_q.push_back(req);
      byte_in(v);
      obs = v;
      ->obs_ev;
      bit_out(k == nbytes - 1);
    end
    if (end_restart) begin
      bus_restart();
      byte_out({7'h60, 1'b0}, 0, ack_n);
      byte_out(8'h09, 0, ack_n);
      byte_out(8'h11, 0, ack_n);
      model[9] = 8'h11;
      bus_stop();
    end else begin
      bus_stop();
      por_m = 1'b0;
    end
    w(12);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int sc;
    m_scl = 1'b1; m_sda = 1'b1; addr_sel = 1'b1;
    s_ok = 1'b1; s_idle = 1'b0; lock = 1'b1; band = 5'h13; adc = 3'b101;
    rst_n = 1'b0;
    load_defaults();
    w(5); rst_n = 1'b1; w(10);

    // R1 reset state
    check_regs("R1");
    check("R1", sda_pull, 0, "sda released");
    check("R1", strobe, 0, "strobe low");

    // R3 single and burst writes
    write_regs(7'h60, 8'h08, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1, 0, 1'b1, "R3");
    check_regs("R3");
    write_regs(7'h60, 8'h05, '{8'hA1, 8'hB2, 8'hC3, 8'h00}, 3, 0, 1'b1, "R3");
    check_regs("R3");

    // R5 strobe on index 1 only
    sc = strobe_cnt;
    write_regs(7'h60, 8'h00, '{8'h12, 8'h34, 8'h00, 8'h00}, 2, 0, 1'b1, "R5");
    check("R5", strobe_cnt - sc, 1, "strobes for index 0..1 burst");
    check_regs("R5");
    sc = strobe_cnt;
    write_regs(7'h60, 8'h02, '{8'h77, 8'h00, 8'h00, 8'h00}, 1, 0, 1'b1, "R5");
    check("R5", strobe_cnt - sc, 0, "strobes for index 2 write");

    // R2 address selection
    write_regs(7'h61, 8'h03, '{8'hEE, 8'h00, 8'h00, 8'h00}, 1, 0, 1'b0, "R2");
    check_regs("R2");
    addr_sel = 1'b0;
    w(4);
    write_regs(7'h61, 8'h03, '{8'h3C, 8'h00, 8'h00, 8'h00}, 1, 0, 1'b1, "R2");
    write_regs(7'h60, 8'h04, '{8'h99, 8'h00, 8'h00, 8'h00}, 1, 0, 1'b0, "R2");
    check_regs("R2");
    addr_sel = 1'b1;
    w(4);

    // R4 pointer beyond the last register
    write_regs(7'h60, 8'h0B, '{8'hE5, 8'h99, 8'h42, 8'h00}, 3, 0, 1'b1, "R4");
    check_regs("R4");
    write_regs(7'h60, 8'h40, '{8'hFF, 8'h00, 8'h00, 8'h00}, 1, 0, 1'b1, "R4");
    check_regs("R4");

    // R8 short spikes on SCL and SDA
    write_regs(7'h60, 8'h04, '{8'hA5, 8'h00, 8'h00, 8'h00}, 1, 1, 1'b1, "R8");
    check_regs("R8");
    write_regs(7'h60, 8'h0A, '{8'h6B, 8'h00, 8'h00, 8'h00}, 1, 2, 1'b1, "R8");
    check_regs("R8");

    // R6 and R7 status reads
    read_status(2, 1'b0, "R7");
    read_status(3, 1'b0, "R6");
    s_ok = 1'b0; s_idle = 1'b1; lock = 1'b0; band = 5'h06; adc = 3'b010;
    w(4);
    read_status(2, 1'b0, "R6");
    check_regs("R6");

    // R7 repeated START keeps the power-on flag; reset restores defaults (R1)
    rst_n = 1'b0; w(3); rst_n = 1'b1; w(10);
    load_defaults();
    check_regs("R1");
    read_status(1, 1'b1, "R7");
    check_regs("R7");
    read_status(2, 1'b0, "R7");
    read_status(1, 1'b0, "R7");

    check("R9", sda_pull, 0, "sda released when idle");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule